// File: doc/BRIEF.md
# Frequency Lock Monitor with Alarm

This block checks that a recovered clock runs at the same frequency as a reference clock. It counts recovered-clock edges over a fixed window of reference-clock cycles. It then compares that count with the window length. If the two differ by more than a small tolerance, which is about half a percent with the default parameters, the block flags loss of frequency lock.

When it flags loss of lock, it raises a level alarm and sends a one-cycle reacquire strobe to a PLL acquisition controller. That controller then restores both frequency and phase. The alarm stays high until a measurement falls back inside the window. It never stays high for less than a fixed minimum number of reference cycles, so slow status logic can see it without an external latch.

The recovered-clock count crosses into the reference domain through a toggle request/acknowledge handshake with two-flop synchronisers in each direction. All outputs are registered in the reference domain.

Top module: `freq_lock_monitor`

## Requirements
- R1: While reset is active and in the first cycle after it, `lockAlarm` is 1 and `reacqPulse` is 0.
- R2: After reset, the first completed measurement only serves as a baseline. `lockAlarm` stays 1 until a later measurement is found in-window.
- R3: A measurement covers WIN_CYCLES (default 2048) reference cycles. Let the error be the absolute difference between the recovered-edge count and WIN_CYCLES. An error of TOL_COUNT (default 10) or less is in-window. A recovered clock 0.3% slow or fast therefore keeps `lockAlarm` at 0.
- R4: An error above TOL_COUNT makes `lockAlarm` rise. With the defaults, a recovered clock 1% slow does this.
- R5: `reacqPulse` is high for exactly one reference cycle. It rises in the same cycle that `lockAlarm` rises from 0.
- R6: While `lockAlarm` stays high, further out-of-window measurements produce no further `reacqPulse`.
- R7: Once `lockAlarm` has risen, it stays high for at least MIN_HOLD (default 32) reference cycles. After that it falls only once an in-window measurement has been seen, and no out-of-window measurement has followed it.
- R8: Detection is symmetric. A recovered clock 1% fast is flagged just like one 1% slow, and it issues a new `reacqPulse` after a locked period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock; all outputs are in this domain |
| recClk | input | 1 | Recovered clock under test |
| rstN | input | 1 | Active-low asynchronous reset for both domains |
| lockAlarm | output | 1 | High while frequency lock is lost or not yet confirmed |
| reacqPulse | output | 1 | One-cycle request to reacquire frequency and phase |

## Verification
A clock change is only reported after the next window boundary and two synchroniser crossings. The window in progress at the change mixes the old and new rates, so only the window after it gives a clean result. For this reason each check of `lockAlarm` and the running `reacqPulse` count is taken three full windows (6144 reference cycles) after the recovered clock is changed. That is at least one clean measurement plus handshake latency, and well ahead of any later stimulus.

Pulse width and alarm hold are not tied to a checkpoint. The bench measures them on every falling reference edge throughout the run and checks the results at the end.

// File: rtl/flm_pkg.sv
`timescale 1ns/1ps
package flm_pkg;
  // Strobes from the datapath to the alarm control, one reference cycle each
  typedef struct packed {
    logic measValid;    // a measurement has completed and is usable
    logic outOfWindow;  // that measurement exceeded the tolerance
  } flm_stb_t;
endpackage

// File: rtl/flm_datapath.sv
`timescale 1ns/1ps
module flm_datapath
  import flm_pkg::*;
#(
  parameter int WIN_CYCLES = 2048,
  parameter int TOL_COUNT  = 10
) (
  input  logic     refClk,
  input  logic     recClk,
  input  logic     rstN,
  output flm_stb_t stb
);
  localparam int WIN_W = $clog2(WIN_CYCLES);
  localparam int CNT_W = WIN_W + 2;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);
  localparam logic [CNT_W-1:0] WIN_REF  = CNT_W'(WIN_CYCLES);
  localparam logic [CNT_W-1:0] TOL_REF  = CNT_W'(TOL_COUNT);

  // Reference domain: window timer and request toggle
  logic [WIN_W-1:0] winCnt;
  logic             reqTog;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
      reqTog <= 1'b0;
    end else if (winCnt == WIN_LAST) begin
      winCnt <= '0;
      reqTog <= ~reqTog;
    end else begin
      winCnt <= winCnt + 1'b1;
    end
  end

  // Recovered domain: free-running edge count, snapshot on each request
  logic [2:0]       reqSync;
  logic [CNT_W-1:0] recCnt;
  logic [CNT_W-1:0] recSnap;
  logic             ackTog;
  logic             reqEdge;

  assign reqEdge = reqSync[2] ^ reqSync[1];

  always_ff @(posedge recClk or negedge rstN) begin
    if (!rstN) begin
      reqSync <= '0;
      recCnt  <= '0;
      recSnap <= '0;
      ackTog  <= 1'b0;
    end else begin
      reqSync <= {reqSync[1:0], reqTog};
      recCnt  <= recCnt + 1'b1;
      if (reqEdge) begin
        recSnap <= recCnt;
        ackTog  <= ~ackTog;
      end
    end
  end

  // Reference domain: take the stable snapshot once the acknowledge arrives
  logic [2:0]       ackSync;
  logic [CNT_W-1:0] prevSnap;
  logic             primed;
  logic             ackEdge;
  logic [CNT_W-1:0] delta;
  logic [CNT_W-1:0] errMag;
  logic             outOfWin;

  assign ackEdge = ackSync[2] ^ ackSync[1];

  always_comb begin
    delta = recSnap - prevSnap;
    if (delta >= WIN_REF) errMag = delta - WIN_REF;
    else                  errMag = WIN_REF - delta;
    outOfWin = (errMag > TOL_REF);
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      ackSync  <= '0;
      prevSnap <= '0;
      primed   <= 1'b0;
      stb      <= '0;
    end else begin
      ackSync         <= {ackSync[1:0], ackTog};
      stb.measValid   <= ackEdge && primed;
      stb.outOfWindow <= ackEdge && primed && outOfWin;
      if (ackEdge) begin
        prevSnap <= recSnap;
        primed   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/flm_control.sv
`timescale 1ns/1ps
module flm_control
  import flm_pkg::*;
#(
  parameter int MIN_HOLD = 32
) (
  input  logic     refClk,
  input  logic     rstN,
  input  flm_stb_t stb,
  output logic     lockAlarm,
  output logic     reacqPulse
);
  localparam int HOLD_W = $clog2(MIN_HOLD + 1);
  localparam logic [HOLD_W-1:0] HOLD_DONE = HOLD_W'(MIN_HOLD);

  logic [HOLD_W-1:0] holdCnt;
  logic              clrPend;
  logic              holdMet;

  assign holdMet = (holdCnt == HOLD_DONE);

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      lockAlarm  <= 1'b1;
      reacqPulse <= 1'b0;
      holdCnt    <= '0;
      clrPend    <= 1'b0;
    end else begin
      reacqPulse <= 1'b0;
      if (lockAlarm && !holdMet) holdCnt <= holdCnt + 1'b1;
      // Release once hold has elapsed and an in-window result is pending
      if (lockAlarm && clrPend && holdMet) begin
        lockAlarm <= 1'b0;
        clrPend   <= 1'b0;
      end
      if (stb.measValid) begin
        if (stb.outOfWindow) begin
          clrPend   <= 1'b0;
          lockAlarm <= 1'b1;
          if (!lockAlarm) begin
            holdCnt    <= '0;
            reacqPulse <= 1'b1;
          end
        end else if (lockAlarm) begin
          clrPend <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/freq_lock_monitor.sv
`timescale 1ns/1ps
module freq_lock_monitor
  import flm_pkg::*;
#(
  parameter int WIN_CYCLES = 2048,
  parameter int TOL_COUNT  = 10,
  parameter int MIN_HOLD   = 32
) (
  input  logic refClk,
  input  logic recClk,
  input  logic rstN,
  output logic lockAlarm,
  output logic reacqPulse
);
  flm_stb_t stb;

  flm_datapath #(.WIN_CYCLES(WIN_CYCLES), .TOL_COUNT(TOL_COUNT)) u_dp (
    .refClk(refClk),
    .recClk(recClk),
    .rstN  (rstN),
    .stb   (stb)
  );

  flm_control #(.MIN_HOLD(MIN_HOLD)) u_ctl (
    .refClk    (refClk),
    .rstN      (rstN),
    .stb       (stb),
    .lockAlarm (lockAlarm),
    .reacqPulse(reacqPulse)
  );
endmodule

// File: rtl/flm_checker.sv
`timescale 1ns/1ps
module flm_checker
  import flm_pkg::*;
#(
  parameter int MIN_HOLD = 32
) (
  input logic     refClk,
  input logic     rstN,
  input logic     lockAlarm,
  input logic     reacqPulse,
  input flm_stb_t stb
);
  // Saturating count of cycles the alarm has been high
  logic [7:0] highRun;
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                     highRun <= '0;
    else if (!lockAlarm)           highRun <= '0;
    else if (highRun != 8'hFF)     highRun <= highRun + 1'b1;
  end

  a_r5_single_pulse: assert property (@(posedge refClk) disable iff (!rstN)
    reacqPulse |=> !reacqPulse);

  a_r5_pulse_on_rise: assert property (@(posedge refClk) disable iff (!rstN)
    reacqPulse |-> $rose(lockAlarm));

  a_r6_no_repeat: assert property (@(posedge refClk) disable iff (!rstN)
    (lockAlarm && $past(lockAlarm)) |-> !reacqPulse);

  a_r4_rise_from_meas: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(lockAlarm) |-> $past(stb.measValid && stb.outOfWindow));

  a_r7_min_hold: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(lockAlarm) |-> (highRun >= 8'(MIN_HOLD)));
endmodule

bind freq_lock_monitor flm_checker #(.MIN_HOLD(MIN_HOLD)) u_flm_chk (
  .refClk    (refClk),
  .rstN      (rstN),
  .lockAlarm (lockAlarm),
  .reacqPulse(reacqPulse),
  .stb       (stb)
);

// File: tb/test_freq_lock_monitor.sv
`timescale 1ns/1ps
module test_freq_lock_monitor;
  localparam int WIN  = 2048;
  localparam int HOLD = 32;
  localparam int SETTLE = 3 * WIN;

  logic refClk = 1'b0;
  logic recClk = 1'b0;
  logic rstN   = 1'b0;
  logic lockAlarm, reacqPulse;
  real  recHalf = 10.0;

  int checks = 0;
  int fails  = 0;
  int reacqCount = 0;
  int wideSeen = 0;
  int curRun = 0;
  int minRun = 1000000;
  logic prevPulse = 1'b0;

  typedef struct {
    string tag;
    logic  alarm;
    int    reacqs;
  } exp_t;
  exp_t expQ[$];
  event chkEv;

  freq_lock_monitor i_freq_lock_monitor (
    .refClk(refClk), .recClk(recClk), .rstN(rstN),
    .lockAlarm(lockAlarm), .reacqPulse(reacqPulse)
  );

  always #10 refClk = ~refClk;  // 50 MHz
  always begin
    #(recHalf) recClk = ~recClk;
  end

  task automatic report(input string tag, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // Pulse width, pulse count and alarm high-run tracking
  always @(negedge refClk) begin
    if (rstN) begin
      if (reacqPulse) reacqCount++;
      if (reacqPulse && prevPulse) wideSeen++;
      prevPulse = reacqPulse;
      if (lockAlarm) curRun++;
      else begin
        if (curRun > 0 && curRun < minRun) minRun = curRun;
        curRun = 0;
      end
    end
  end

  // Driver: set the recovered clock, wait, push the expected state
  task automatic expectAfter(input real half, input int cycles, input string tag,
                             input logic alarm, input int reacqs);
    exp_t e;
    recHalf = half;
    repeat (cycles) @(posedge refClk);
    e.tag = tag; e.alarm = alarm; e.reacqs = reacqs;
    expQ.push_back(e);
    ->chkEv;
  endtask

  // Monitor: pop and compare
  initial begin
    forever begin
      @(chkEv);
      @(negedge refClk);
      #1;
      while (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        report(e.tag, "lockAlarm", int'(lockAlarm), int'(e.alarm));
        report(e.tag, "reacq count", reacqCount, e.reacqs);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge refClk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(posedge refClk);
    @(negedge refClk);
    report("R1", "lockAlarm in reset", int'(lockAlarm), 1);
    report("R1", "reacqPulse in reset", int'(reacqPulse), 0);
    rstN = 1'b1;
    expectAfter(10.0, 1, "R1", 1'b1, 0);
    expectAfter(10.0, 3000, "R2 baseline only", 1'b1, 0);
    expectAfter(10.0, 3200, "R2 first in-window", 1'b0, 0);
    expectAfter(10.1, SETTLE, "R4 slow 1%", 1'b1, 1);
    expectAfter(10.1, SETTLE, "R6 stays out", 1'b1, 1);
    expectAfter(10.0, SETTLE, "R7 relock", 1'b0, 1);
    expectAfter(10.03, SETTLE, "R3 slow 0.3%", 1'b0, 1);
    expectAfter(9.97, SETTLE, "R3 fast 0.3%", 1'b0, 1);
    expectAfter(9.9, SETTLE, "R8 fast 1%", 1'b1, 2);
    expectAfter(10.0, SETTLE, "R8 relock", 1'b0, 2);
    wait (expQ.size() == 0);
    repeat (4) @(posedge refClk);
    report("R5", "wide reacq pulses", wideSeen, 0);
    report("R7", "min alarm run >= hold", int'(minRun >= HOLD), 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule